// File: doc/BRIEF.md
# Slow-Clock Watchdog with Early-Warning Alarm

This block is a watchdog timer that runs on the always-on slow clock, so it keeps counting while the rest of the chip sleeps. Software programs a reload value and an alarm threshold, then enables the timer. The timer loads the reload value and counts down by one on every slow-clock cycle. Software keeps the system alive by writing a key word to the feed register, which reloads the counter.

If feeding stops, the count first crosses the alarm threshold. The block then raises a level interrupt, which gives software a last chance to record its context or to feed. If the count then runs out, the block drives a fixed-length system reset pulse and stops. It also sets a reboot flag. That flag is cleared only by power-on reset or by software, so after the reboot software can tell that the watchdog caused it.

The register port is a single-cycle write strobe with a 3-bit address, plus a combinational read. The block's own reset input is the power-on reset. The reset pulse it generates is not fed back into the block.

Top module: `slowclk_watchdog`

## Requirements
- R1: After reset, every register reads zero, `alarm_irq` is low and `sys_rst_o` is low. Register map: address 0 is control (bit 0 = run enable), 1 is reload value, 2 is alarm threshold, 3 is feed (write-only, reads zero), 4 is status (bit 0 = alarm pending, bit 1 = reboot flag).
- R2: Writing 1 to control bit 0 while stopped loads the reload value R. `sys_rst_o` is high from the R+1-th clock edge after the edge that samples that write.
- R3: The reset pulse lasts exactly PULSE_LEN cycles (4 by default). When it starts, control bit 0 reads 0, and no further pulse follows until the timer is enabled again.
- R4: For a threshold A below R, the alarm pending bit and `alarm_irq` go high R-A edges after the loading edge, which is when the count reaches A.
- R5: If the threshold is greater than or equal to the value just loaded, the alarm goes high on the first count edge after the load.
- R6: The alarm is a level that stays high until software clears it. It fires at most once per load. After it has been cleared, it does not fire again until the next load, not even on the expiry edge.
- R7: A write of 0xACCE55ED to address 3 while running reloads the counter, even with the alarm pending. A write of any other value there has no effect on the count.
- R8: Writing 0 to control bit 0 stops counting, and no alarm or reset follows. Enabling again reloads from the reload value.
- R9: Expiry sets status bit 1. The bit survives the generated reset pulse. Writing 1 to status bit 1 clears it, and writing 0 does not.
- R10: The alarm threshold register is ALARM_W bits wide (16 by default). Upper write bits are dropped, and the upper read bits are zero.
- R11: Writing 1 to status bit 0 clears the alarm pending bit and drops `alarm_irq` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock; one count per rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Early-warning interrupt level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
Every result is due a fixed number of clock edges after the edge that samples the write that caused it. Status and interrupt changes show one edge after a write or count event. The alarm shows R-A edges after a load, and the reset shows R+1 edges after it. The pulse stays high for PULSE_LEN cycles. The bench counts edges from the sampling edge of each write, and it compares outputs half a cycle after each edge, against a behavioural model that is stepped on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_RELOAD = 3'd1,
    ADDR_ALARM  = 3'd2,
    ADDR_FEED   = 3'd3,
    ADDR_STATUS = 3'd4
  } reg_addr_e;

  localparam logic [DATA_W-1:0] FEED_KEY = 32'hACCE_55ED;

  localparam int unsigned ST_PEND_BIT = 0;
  localparam int unsigned ST_FLAG_BIT = 1;

  // Commands decoded from the register port for the counter
  typedef struct packed {
    logic run_on;
    logic run_off;
    logic feed;
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ALARM_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                run,
  input  logic                alarm_hit,
  input  logic                expire,
  output wdt_cmd_t            cmd,
  output logic [CNT_W-1:0]    reload_q,
  output logic [ALARM_W-1:0]  alarm_q,
  output logic                alarm_pend,
  output logic                reboot_flag,
  output logic [DATA_W-1:0]   reg_rdata
);
  logic wr_ctrl, wr_reload, wr_alarm, wr_feed, wr_status;
  logic pend_d, flag_d;
  logic [DATA_W-1:0] alarm_rd;

  // Write decode
  always_comb begin
    wr_ctrl   = reg_we && (reg_addr == ADDR_CTRL);
    wr_reload = reg_we && (reg_addr == ADDR_RELOAD);
    wr_alarm  = reg_we && (reg_addr == ADDR_ALARM);
    wr_feed   = reg_we && (reg_addr == ADDR_FEED);
    wr_status = reg_we && (reg_addr == ADDR_STATUS);
    cmd.run_on  = wr_ctrl && reg_wdata[0];
    cmd.run_off = wr_ctrl && !reg_wdata[0];
    cmd.feed    = wr_feed && (reg_wdata == FEED_KEY);
  end

  // Sticky status: a new event wins over a same-cycle clear
  always_comb begin
    pend_d = alarm_hit || (alarm_pend && !(wr_status && reg_wdata[ST_PEND_BIT]));
    flag_d = expire || (reboot_flag && !(wr_status && reg_wdata[ST_FLAG_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
    end else if (wr_alarm) begin
      alarm_q <= reg_wdata[ALARM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_pend  <= 1'b0;
      reboot_flag <= 1'b0;
    end else begin
      alarm_pend  <= pend_d;
      reboot_flag <= flag_d;
    end
  end

  // Threshold readback, zero padded when narrower than the bus
  generate
    if (ALARM_W < DATA_W) begin : g_alarm_pad
      assign alarm_rd = {{(DATA_W-ALARM_W){1'b0}}, alarm_q};
    end else begin : g_alarm_full
      assign alarm_rd = alarm_q;
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL:   reg_rdata[0] = run;
      ADDR_RELOAD: reg_rdata = DATA_W'(reload_q);
      ADDR_ALARM:  reg_rdata = alarm_rd;
      ADDR_STATUS: begin
        reg_rdata[ST_PEND_BIT] = alarm_pend;
        reg_rdata[ST_FLAG_BIT] = reboot_flag;
      end
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ALARM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdt_cmd_t           cmd,
  input  logic [CNT_W-1:0]   reload,
  input  logic [ALARM_W-1:0] alarm,
  output logic               run,
  output logic               alarm_hit,
  output logic               expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, step_val;
  logic             run_q, run_d;
  logic             armed_q, armed_d;
  logic             load, cnt_en;

  assign run = run_q;

  always_comb begin
    cnt_d     = cnt_q;
    run_d     = run_q;
    armed_d   = armed_q;
    alarm_hit = 1'b0;
    expire    = 1'b0;
    step_val  = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    load      = 1'b0;
    if (cmd.run_off) begin
      run_d = 1'b0;
    end else if ((cmd.run_on && !run_q) || (cmd.feed && run_q)) begin
      load    = 1'b1;
      cnt_d   = reload;
      run_d   = 1'b1;
      armed_d = 1'b1;
    end else if (run_q) begin
      if (armed_q && (step_val <= CNT_W'(alarm))) begin
        alarm_hit = 1'b1;
        armed_d   = 1'b0;
      end
      if (cnt_q == '0) begin
        expire = 1'b1;
        run_d  = 1'b0;
      end else begin
        cnt_d = step_val;
      end
    end
    cnt_en = load || (run_q && (cnt_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic sys_rst
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = expire || (left_q != '0);
    left_d  = expire ? PW'(PULSE_LEN) : left_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign sys_rst = (left_q != '0);
endmodule

// File: rtl/slowclk_watchdog.sv
module slowclk_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ALARM_W   = 16,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        alarm_irq,
  output logic        sys_rst_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  wdt_cmd_t           cmd;
  logic [CNT_W-1:0]   reload_q;
  logic [ALARM_W-1:0] alarm_q;
  logic               run, alarm_hit, expire;
  logic               alarm_pend, reboot_flag;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  wdt_regs #(.CNT_W(CNT_W), .ALARM_W(ALARM_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .run(run), .alarm_hit(alarm_hit), .expire(expire),
    .cmd(cmd), .reload_q(reload_q), .alarm_q(alarm_q),
    .alarm_pend(alarm_pend), .reboot_flag(reboot_flag),
    .reg_rdata(reg_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W), .ALARM_W(ALARM_W)) cnt_i (
    .clk(clk), .rst_n(rst_n_s),
    .cmd(cmd), .reload(reload_q), .alarm(alarm_q),
    .run(run), .alarm_hit(alarm_hit), .expire(expire)
  );

  wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst_n(rst_n_s),
    .expire(expire), .sys_rst(sys_rst_o)
  );

  assign alarm_irq = alarm_pend;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned ALARM_W   = 16,
  parameter int unsigned PULSE_LEN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        alarm_irq,
  input logic        sys_rst_o,
  input logic        run,
  input logic        reboot_flag
);
  logic [31:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (sys_rst_o) begin
      hi_len <= hi_len + 32'd1;
    end else begin
      hi_len <= '0;
    end
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (hi_len == 32'(PULSE_LEN)));

  // R2
  rst_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(run) && !run));

  // R4
  irq_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(run));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!$rose(alarm_irq) && !$rose(sys_rst_o)));

  // R9
  flag_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reboot_flag) |-> $past(reg_we && (reg_addr == 3'd4) && reg_wdata[1]));

  // R10
  alarm_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2) |-> ((reg_rdata >> ALARM_W) == 32'd0));
endmodule

bind slowclk_watchdog wdt_chk #(.ALARM_W(ALARM_W), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq),
  .sys_rst_o(sys_rst_o), .run(run), .reboot_flag(reboot_flag)
);

// File: tb/slowclk_watchdog_tb_top.sv
`timescale 1ns/1ps
module slowclk_watchdog_tb_top;
  localparam logic [31:0] KEY = 32'hACCE_55ED;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        alarm_irq;
  logic        sys_rst_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  slowclk_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_irq(alarm_irq), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge
  bit          m_run, m_armed, m_pend, m_flag, m_hit, m_exp;
  logic [31:0] m_cnt, m_reload, m_alarm, m_next;
  int          m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_armed = 0; m_pend = 0; m_flag = 0;
      m_cnt = 0; m_reload = 0; m_alarm = 0; m_left = 0;
    end else begin
      m_hit = 0; m_exp = 0;
      if (reg_we && reg_addr == 3'd0) begin
        if (reg_wdata[0]) begin
          if (!m_run) begin m_cnt = m_reload; m_run = 1; m_armed = 1; end
        end else m_run = 0;
      end else if (reg_we && reg_addr == 3'd3 && reg_wdata == KEY && m_run) begin
        m_cnt = m_reload; m_armed = 1;
      end else if (m_run) begin
        m_next = (m_cnt == 0) ? 0 : m_cnt - 1;
        if (m_armed && m_next <= m_alarm) begin m_hit = 1; m_armed = 0; end
        if (m_cnt == 0) begin m_exp = 1; m_run = 0; end
        else m_cnt = m_next;
      end
      if (m_exp) m_left = 4;
      else if (m_left > 0) m_left--;
      if (reg_we && reg_addr == 3'd1) m_reload = reg_wdata;
      if (reg_we && reg_addr == 3'd2) m_alarm = reg_wdata & 32'h0000_FFFF;
      m_pend = m_hit || (m_pend && !(reg_we && reg_addr == 3'd4 && reg_wdata[0]));
      m_flag = m_exp || (m_flag && !(reg_we && reg_addr == 3'd4 && reg_wdata[1]));
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_run};
      3'd1: return m_reload;
      3'd2: return m_alarm;
      3'd4: return {30'd0, m_flag, m_pend};
      default: return 32'd0;
    endcase
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R4 model irq", {31'd0, alarm_irq}, {31'd0, m_pend});
      chk("R2 model rst", {31'd0, sys_rst_o}, {31'd0, m_left > 0});
      chk("R1 model rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_rise(input bit want_rst, output int n);
    n = 0;
    while (((want_rst ? sys_rst_o : alarm_irq) == 1'b0) && n < 1000) begin
      step(); n++;
    end
  endtask

  task automatic drain();
    int w;
    w = 0;
    while (sys_rst_o && w < 100) begin step(); w++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, n2, w;
    bit bad;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    repeat (3) step();
    cmp_on = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reset read", d, 32'd0);
    end
    chk("R1 reset irq", {31'd0, alarm_irq}, 32'd0);
    chk("R1 reset rst", {31'd0, sys_rst_o}, 32'd0);

    // R10: threshold width
    wr(3'd2, 32'hFFFF_1234);
    rd(3'd2, d); chk("R10 alarm width", d, 32'h0000_1234);

    // R2 R3 R4 R9: reload 10, alarm 3
    wr(3'd1, 32'd10); wr(3'd2, 32'd3); wr(3'd0, 32'd1);
    wait_rise(1'b0, n);  chk("R4 alarm latency", n, 7);
    wait_rise(1'b1, n2); chk("R2 expiry latency", n + n2, 11);
    rd(3'd0, d); chk("R3 stopped on expiry", d, 32'd0);
    w = 0;
    while (sys_rst_o && w < 100) begin step(); w++; end
    chk("R3 pulse width", w, 4);
    bad = 0;
    repeat (20) begin step(); if (sys_rst_o) bad = 1; end
    chk("R3 no second pulse", {31'd0, bad}, 32'd0);
    rd(3'd4, d); chk("R9 flag set after expiry", d, 32'd3);

    // R9 R11: status clearing
    wr(3'd4, 32'd0);
    rd(3'd4, d); chk("R9 write zero keeps flag", d, 32'd3);
    wr(3'd4, 32'd1);
    chk("R11 irq cleared", {31'd0, alarm_irq}, 32'd0);
    rd(3'd4, d); chk("R11 pending cleared", d, 32'd2);
    wr(3'd4, 32'd2);
    rd(3'd4, d); chk("R9 flag cleared", d, 32'd0);

    // R5 R6: threshold above reload, then clear before expiry
    wr(3'd1, 32'd5); wr(3'd2, 32'd8); wr(3'd0, 32'd1);
    step();
    chk("R5 alarm on first tick", {31'd0, alarm_irq}, 32'd1);
    wr(3'd4, 32'd1);
    wait_rise(1'b1, n); chk("R2 expiry after clear", n, 4);
    chk("R6 no refire in same countdown", {31'd0, alarm_irq}, 32'd0);
    drain(); wr(3'd4, 32'd3);

    // R7 R6: feed with alarm pending, wrong key ignored
    wr(3'd1, 32'd6); wr(3'd2, 32'd2); wr(3'd0, 32'd1);
    repeat (5) step();
    chk("R7 alarm pending before feed", {31'd0, alarm_irq}, 32'd1);
    wr(3'd3, KEY);
    chk("R7 no reset after feed", {31'd0, sys_rst_o}, 32'd0);
    repeat (2) step();
    wr(3'd3, 32'h1234_5678);
    wait_rise(1'b1, n); chk("R7 wrong key ignored", n, 4);
    chk("R6 irq level held", {31'd0, alarm_irq}, 32'd1);
    drain(); wr(3'd4, 32'd3);

    // R8: disable stops, enable reloads
    wr(3'd1, 32'd4); wr(3'd2, 32'd1); wr(3'd0, 32'd1);
    repeat (2) step();
    wr(3'd0, 32'd0);
    bad = 0;
    repeat (20) begin step(); if (sys_rst_o || alarm_irq) bad = 1; end
    chk("R8 idle after disable", {31'd0, bad}, 32'd0);
    rd(3'd0, d); chk("R8 control reads stopped", d, 32'd0);
    wr(3'd0, 32'd1);
    wait_rise(1'b1, n); chk("R8 reload on enable", n, 5);
    drain();
    repeat (3) step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule